// File: doc/BRIEF.md
# Seek Track Crossing Counter

This block counts track-crossing pulses while an optical pickup moves quickly across many tracks. A host first loads a binary pass length N. When the host's command write strobe falls, a check begins. The block then holds a tracking-off output high so that the tracking loop stays open. It counts rising edges of the crossing input, and it turns its monitor output into a progress flag. The flag rises halfway through each pass and falls when the pass ends.

Each pass covers N+1 crossings. When a pass ends, the block starts the next one by itself, so a long seek is made of many passes. For example, N = 199 with 100 passes covers 20,000 tracks. The host counts the falls of the monitor and sends a stop command when the seek is done. When no check is active, the monitor output passes the normal subcode-ready signal straight through.

Top module: `trkseek_top`

## Requirements
- R1: After reset, `track_off` is 0 and `mon_out` equals `subq_ready`.
- R2: A falling edge of `wr_strobe` starts a check, and `track_off` is 1 from the next cycle. A rising edge of `wr_strobe` does not start a check.
- R3: Once a check is active, `track_off` stays 1 until a stop command is sampled.
- R4: While a check is active, `mon_out` shows the progress flag and ignores `subq_ready`.
- R5: With loaded value N, the progress flag rises on the crossing that brings the count within the pass to (N+1)/2, rounded down.
- R6: The (N+1)th crossing of a pass clears the flag and the count, and the next pass starts by itself with the same N.
- R7: `cross_in` passes through a two-flop synchronizer. Each high pulse is counted once, on its rising edge, however long it lasts. Crossings while no check is active are not counted.
- R8: When `stop_cmd` is sampled, the check ends in that cycle: `track_off` drops, the count clears, and `mon_out` follows `subq_ready` again. Stop wins over a crossing edge in the same cycle.
- R9: A `load_valid` during an active check restarts the pass with the new value. The load wins over a crossing edge in the same cycle, and that edge is not counted.
- R10: With N = 0, every crossing ends a pass and the progress flag never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | One-cycle load command for the pass value |
| load_count | input | CNT_W | Pass value N in binary |
| wr_strobe | input | 1 | Command write strobe; its fall starts a check |
| stop_cmd | input | 1 | One-cycle stop (reset) command |
| cross_in | input | 1 | Asynchronous track-crossing pulses |
| subq_ready | input | 1 | Normal subcode-ready indication |
| track_off | output | 1 | High while a check is active |
| mon_out | output | 1 | Progress flag while active, otherwise `subq_ready` |

## Verification
Two pairs of events can land on the same clock edge. The first is a synchronized crossing edge together with a stop command. The second is that edge together with a new load. The bench raises `cross_in` and then places `stop_cmd` or `load_valid` exactly on the third edge, which is the edge where the crossing would be counted. For the load case, the pass after the load shows whether the colliding crossing was dropped: a wrong count moves the moment the flag rises and falls. For the stop case, the bench checks that the tracking-off output drops.

// File: rtl/trk_pkg.sv
// Package: shared width default and the event record that the pass
// counter hands to the controller.
package trk_pkg;
    localparam int TRK_CNT_W = 16;

    // Events raised by the counter for one crossing edge
    typedef struct packed {
        logic half_hit;   // this edge reached the halfway count
        logic pass_end;   // this edge completed the pass
    } trk_evt_t;
endpackage

// File: rtl/trk_sync_edge.sv
// trk_sync_edge: brings an asynchronous level into the clock domain
// through STAGES flops and gives a one-cycle pulse on each rising edge.
// Assumes each input pulse is high and low for at least STAGES cycles.
module trk_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain built stage by stage
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= din;
                end
            end else begin : g_next
                // Later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized level, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/trk_pass_counter.sv
// trk_pass_counter: counts crossings inside one pass of target+1 crossings.
// It reports the halfway edge and the completing edge, and wraps to zero
// by itself. Assumes clr takes priority over cnt_en.
module trk_pass_counter
    import trk_pkg::*;
#(
    parameter int CNT_W = TRK_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] cnt_q,
    output trk_evt_t         evt
);
    logic [CNT_W:0]   half_wide;
    logic [CNT_W-1:0] half_pt;
    logic [CNT_W-1:0] cnt_nxt;

    // Halfway point (target+1)/2, computed one bit wider to avoid overflow
    always_comb begin
        half_wide = ({1'b0, target} + {{CNT_W{1'b0}}, 1'b1}) >> 1;
        half_pt   = half_wide[CNT_W-1:0];
        cnt_nxt   = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // Event decode for the current crossing edge
    always_comb begin
        evt.pass_end = cnt_en && !clr && (cnt_q == target);
        evt.half_hit = cnt_en && !clr && !evt.pass_end && (cnt_nxt == half_pt);
    end

    // Crossing count: clear, wrap at end of pass, or step
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr)          cnt_q <= '0;
        else if (evt.pass_end) cnt_q <= '0;
        else if (cnt_en)       cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/trk_seek_ctrl.sv
// trk_seek_ctrl: holds the active state of the check and the progress flag,
// and selects what the monitor output shows. Priority: stop, then
// start or load, then counter events. wr_strobe is assumed synchronous.
module trk_seek_ctrl
    import trk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_strobe,
    input  logic     stop_cmd,
    input  logic     load_valid,
    input  logic     subq_ready,
    input  trk_evt_t evt,
    output logic     active_q,
    output logic     restart,
    output logic     mon_out
);
    logic strobe_prev_q;
    logic strobe_fall;
    logic mon_q;

    // Previous strobe level, used to find its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev_q <= 1'b0;
        else        strobe_prev_q <= wr_strobe;
    end

    assign strobe_fall = strobe_prev_q & ~wr_strobe;
    assign restart     = stop_cmd | strobe_fall | load_valid;

    // Check-active state: set by strobe fall, cleared by stop
    always_ff @(posedge clk) begin
        if (!rst_n)           active_q <= 1'b0;
        else if (stop_cmd)    active_q <= 1'b0;
        else if (strobe_fall) active_q <= 1'b1;
    end

    // Progress flag: high from the halfway edge until the end of the pass
    always_ff @(posedge clk) begin
        if (!rst_n)            mon_q <= 1'b0;
        else if (restart)      mon_q <= 1'b0;
        else if (evt.pass_end) mon_q <= 1'b0;
        else if (evt.half_hit) mon_q <= 1'b1;
    end

    assign mon_out = active_q ? mon_q : subq_ready;
endmodule

// File: rtl/trkseek_top.sv
// trkseek_top: track crossing counter for seeks. Holds the loaded pass
// value and connects the synchronizer, the pass counter and the controller.
// Assumes load_valid and stop_cmd are one-cycle synchronous pulses.
module trkseek_top
    import trk_pkg::*;
#(
    parameter int CNT_W       = TRK_CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_valid,
    input  logic [CNT_W-1:0] load_count,
    input  logic             wr_strobe,
    input  logic             stop_cmd,
    input  logic             cross_in,
    input  logic             subq_ready,
    output logic             track_off,
    output logic             mon_out
);
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cross_rise;
    logic             active_q;
    logic             restart;
    logic             cnt_en;
    trk_evt_t         evt;

    // Pass value register, written by the load command
    always_ff @(posedge clk) begin
        if (!rst_n)          target_q <= '0;
        else if (load_valid) target_q <= load_count;
    end

    trk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cross_in),
        .rise (cross_rise)
    );

    assign cnt_en = active_q & cross_rise;

    trk_pass_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .cnt_en(cnt_en),
        .target(target_q),
        .cnt_q (cnt_q),
        .evt   (evt)
    );

    trk_seek_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .stop_cmd  (stop_cmd),
        .load_valid(load_valid),
        .subq_ready(subq_ready),
        .evt       (evt),
        .active_q  (active_q),
        .restart   (restart),
        .mon_out   (mon_out)
    );

    assign track_off = active_q;
endmodule

// File: rtl/trkseek_checker.sv
// trkseek_checker: properties of the seek counter, bound to trkseek_top.
module trkseek_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_strobe,
    input logic             stop_cmd,
    input logic             load_valid,
    input logic             subq_ready,
    input logic             track_off,
    input logic             mon_out,
    input logic             half_hit,
    input logic             pass_end,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] target
);
    // R2: a strobe fall without stop starts the check
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_strobe) && !stop_cmd) |=> track_off);

    // R3: the check holds until stop
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (track_off && !stop_cmd) |=> track_off);

    // R5: the flag rises only after a halfway event
    p_mon_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mon_out) && track_off && $past(track_off)) |-> $past(half_hit));

    // R6: end of pass drops the flag, check goes on
    p_pass_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && !stop_cmd && !load_valid) |=> (track_off && !mon_out));

    // R6: the count never exceeds the pass value
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        track_off |-> (cnt <= target));

    // R8: stop ends the check and restores the normal monitor
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (!track_off && (mon_out == subq_ready)));
endmodule

bind trkseek_top trkseek_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .stop_cmd  (stop_cmd),
    .load_valid(load_valid),
    .subq_ready(subq_ready),
    .track_off (track_off),
    .mon_out   (mon_out),
    .half_hit  (evt.half_hit),
    .pass_end  (evt.pass_end),
    .cnt       (cnt_q),
    .target    (target_q)
);

// File: tb/sim_trkseek_top.sv
module sim_trkseek_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_valid = 1'b0;
    logic [W-1:0] load_count = '0;
    logic         wr_strobe = 1'b0;
    logic         stop_cmd = 1'b0;
    logic         cross_in = 1'b0;
    logic         subq_ready = 1'b0;
    logic         track_off;
    logic         mon_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic         m_act = 0;
    logic         m_mon = 0;
    logic [W-1:0] m_n = '0;
    logic [W-1:0] m_cnt = '0;

    always #10 clk = ~clk;

    trkseek_top #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_count(load_count),
        .wr_strobe(wr_strobe), .stop_cmd(stop_cmd), .cross_in(cross_in),
        .subq_ready(subq_ready), .track_off(track_off), .mon_out(mon_out)
    );

    function automatic logic [W-1:0] half_of(input logic [W-1:0] n);
        logic [W:0] t;
        t = ({1'b0, n} + 1) >> 1;
        return t[W-1:0];
    endfunction

    function automatic logic exp_mon();
        return m_act ? m_mon : subq_ready;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " track_off"}, track_off, m_act);
        chk({req, " mon_out"}, mon_out, exp_mon());
    endtask

    // Model of one counted crossing
    task automatic model_cross();
        if (m_act) begin
            if (m_cnt == m_n) begin
                m_cnt = '0;
                m_mon = 0;
            end else begin
                m_cnt = m_cnt + 1;
                if (m_cnt == half_of(m_n)) m_mon = 1;
            end
        end
    endtask

    task automatic do_cross(input int hi);
        @(negedge clk) cross_in = 1'b1;
        repeat (hi) @(negedge clk);
        cross_in = 1'b0;
        repeat (3) @(negedge clk);
        model_cross();
    endtask

    task automatic do_load(input logic [W-1:0] v);
        @(negedge clk) begin load_valid = 1'b1; load_count = v; end
        @(negedge clk) load_valid = 1'b0;
        m_n = v; m_cnt = '0; m_mon = 0;
    endtask

    task automatic do_start();
        @(negedge clk) wr_strobe = 1'b1;
        @(negedge clk) wr_strobe = 1'b0;
        @(negedge clk);
        m_act = 1; m_cnt = '0; m_mon = 0;
    endtask

    task automatic do_stop();
        @(negedge clk) stop_cmd = 1'b1;
        @(negedge clk) stop_cmd = 1'b0;
        m_act = 0; m_cnt = '0; m_mon = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_state("R1 reset sq0");
        subq_ready = 1'b1; #1;
        chk_state("R1 reset sq1");

        // R2 strobe rise alone does not start
        @(negedge clk) wr_strobe = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 rise no start", track_off, 1'b0);
        @(negedge clk) wr_strobe = 1'b0;
        @(negedge clk);
        m_act = 1; m_cnt = '0; m_mon = 0;
        chk("R2 fall starts", track_off, 1'b1);
        do_stop();
        chk_state("R8 stop");

        // R7 idle crossings ignored, long pulse counted once
        subq_ready = 1'b0;
        do_load(16'd3);
        do_cross(2);
        chk_state("R7 idle ignored");
        do_start();
        do_cross(12);
        chk_state("R7 long pulse once");
        do_cross(2);
        chk_state("R5 half N3");
        subq_ready = 1'b0; #1;
        chk_state("R4 sq ignored 0");
        subq_ready = 1'b1; #1;
        chk_state("R4 sq ignored 1");
        do_cross(2); do_cross(2);
        chk_state("R6 pass end N3");
        chk("R3 still active", track_off, 1'b1);

        // R5 R6: value 199, two passes, check every crossing
        do_load(16'd199);
        for (int i = 0; i < 400; i++) begin
            do_cross(2);
            chk_state("R6 N199 pass");
        end

        // R10 N=0
        do_load(16'd0);
        for (int i = 0; i < 5; i++) begin
            do_cross(2);
            chk("R10 flag stays low", mon_out, 1'b0);
        end

        // R9 load while active with a colliding edge
        do_load(16'd3);
        do_cross(2);
        @(negedge clk) cross_in = 1'b1;
        repeat (2) @(negedge clk);
        load_valid = 1'b1; load_count = 16'd1;
        @(negedge clk) begin load_valid = 1'b0; cross_in = 1'b0; end
        repeat (3) @(negedge clk);
        m_n = 16'd1; m_cnt = '0; m_mon = 0;
        chk_state("R9 load wins");
        do_cross(2);
        chk_state("R9 new value half");
        do_cross(2);
        chk_state("R9 new value end");

        // R8 stop with a colliding edge
        do_cross(2);
        @(negedge clk) cross_in = 1'b1;
        repeat (2) @(negedge clk);
        stop_cmd = 1'b1;
        @(negedge clk) begin stop_cmd = 1'b0; cross_in = 1'b0; end
        m_act = 0; m_cnt = '0; m_mon = 0;
        repeat (3) @(negedge clk);
        chk_state("R8 stop wins");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r <= 5)      do_cross($urandom_range(2, 5));
            else if (r == 6) do_load(16'($urandom_range(0, 6)));
            else if (r == 7) do_start();
            else if (r == 8) do_stop();
            else begin
                @(negedge clk) subq_ready = ~subq_ready;
            end
            #1;
            chk_state("R6 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule